// File: doc/BRIEF.md
# Soft-Reset Hold-Off Gate for System Management Mode

This block sits in system logic between whatever raises a soft-reset request and the processor's soft-reset input. It watches the processor's active-low indication that System Management Mode is in progress. While that indication is asserted, and for a fixed guard window after it goes inactive, no soft reset can reach the processor. This protects the protected memory region while the mode-exit sequence completes.

A request that arrives during hold-off is not lost. It is recorded in a single pending flag and replayed as one soft-reset pulse on the first cycle that hold-off ends. Any number of requests raised during one hold-off period merge into that single replay. Outside hold-off, a request is passed on with one register of latency.

The hard global reset is never gated. It goes to the processor unchanged, and it also returns the gate to idle.

Top module: `smm_srst_gate`

## Requirements
- R1: After global reset is released, `srst_pulse` is 0 and no replay is pending.
- R2: While `smm_act_n` is 0 in a cycle, `srst_pulse` is 0 in the following cycle, whatever `srst_req` does.
- R3: Counting the first cycle in which `smm_act_n` is seen high again as exit cycle 1, hold-off lasts through exit cycle `GUARD_CYCLES`+1 (21 with the default of 20). A request made in any of those cycles produces no pulse in the cycle after it.
- R4: A request made during hold-off is held. It is issued as a single-cycle `srst_pulse`, one cycle after the first cycle in which hold-off is released, and is then forgotten.
- R5: Several requests made during one hold-off period produce exactly one replayed pulse.
- R6: If `smm_act_n` falls again while the guard window is still running, the window is abandoned. Hold-off continues until the next exit, and a full guard window is then counted from that exit.
- R7: When hold-off is not in effect, a request (`srst_req` = 1) in a cycle gives `srst_pulse` = 1 in the next cycle. A request held high gives a pulse in every such cycle.
- R8: `cpu_hard_rst_n` always equals `glb_rst_n`, with no gating. Asserting `glb_rst_n` (active low) discards any pending replay and any running guard window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processor clock |
| glb_rst_n | input | 1 | Hard global reset, active low, asynchronous assert |
| smm_act_n | input | 1 | Management-mode active indication from the processor, active low |
| srst_req | input | 1 | Soft-reset request from system logic, sampled every cycle |
| srst_pulse | output | 1 | Gated soft reset to the processor, registered |
| cpu_hard_rst_n | output | 1 | Hard reset to the processor, a direct copy of `glb_rst_n` |

## Verification
The assertions assume that `smm_act_n` and `srst_req` are synchronous to `clk` and stable around its rising edge. They also assume that the checker's own window counter starts with the mode indication inactive, as it does after every reset. The stimulus meets these assumptions: it changes both inputs only on the falling edge, and it releases global reset only while `smm_act_n` is high. Each scenario therefore begins from an idle gate, with no exit edge straddling the reset release.

// File: rtl/smm_srst_pkg.sv
package smm_srst_pkg;

  // Default length of the post-exit hold-off window, in clock cycles.
  localparam int unsigned GUARD_DEFAULT = 20;

  // Default number of flops in the reset release synchronizer.
  localparam int unsigned SYNC_DEFAULT = 2;

  // Hold-off condition reported by the exit guard.
  typedef enum logic [1:0] {
    GATE_OPEN  = 2'b00,
    GATE_SMM   = 2'b01,
    GATE_GUARD = 2'b10
  } gate_state_e;

  // Width of a down-counter that must hold the value n.
  function automatic int unsigned cnt_width(input int unsigned n);
    return (n < 2) ? 1 : $clog2(n + 1);
  endfunction

endpackage

// File: rtl/smm_srst_rst_sync.sv
module smm_srst_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_sync
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  generate
    if (STAGES == 1) begin : g_one
      always_comb sync_d = 1'b1;
    end else begin : g_many
      always_comb sync_d = {sync_q[STAGES-2:0], 1'b1};
    end
  endgenerate

  // Assert asynchronously, release through the flop chain.
  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= '0;
    else         sync_q <= sync_d;
  end

  assign rst_n_sync = sync_q[STAGES-1];

endmodule

// File: rtl/smm_srst_exit_guard.sv
module smm_srst_exit_guard
  import smm_srst_pkg::*;
#(
  parameter int unsigned GUARD_CYCLES = GUARD_DEFAULT
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        smm_act_n,
  output logic        hold_off,
  output gate_state_e gate_state
);

  localparam int unsigned GW = cnt_width(GUARD_CYCLES);
  localparam logic [GW-1:0] RELOAD = GW'(GUARD_CYCLES);

  logic          smm_n_q;
  logic          smm_n_d;
  logic [GW-1:0] guard_q;
  logic [GW-1:0] guard_d;
  logic          guard_en;
  logic          exit_edge;
  logic          in_smm;

  assign in_smm    = !smm_act_n;
  assign exit_edge = smm_act_n && !smm_n_q;

  // Next state of the guard down-counter.
  always_comb begin
    smm_n_d  = smm_act_n;
    guard_d  = guard_q;
    guard_en = 1'b0;
    if (in_smm) begin
      guard_d  = '0;
      guard_en = (guard_q != '0);
    end else if (exit_edge) begin
      guard_d  = RELOAD;
      guard_en = 1'b1;
    end else if (guard_q != '0) begin
      guard_d  = guard_q - 1'b1;
      guard_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) smm_n_q <= 1'b1;
    else        smm_n_q <= smm_n_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        guard_q <= '0;
    else if (guard_en) guard_q <= guard_d;
  end

  always_comb begin
    if (in_smm)                              gate_state = GATE_SMM;
    else if (exit_edge || guard_q != '0)     gate_state = GATE_GUARD;
    else                                     gate_state = GATE_OPEN;
  end

  assign hold_off = (gate_state != GATE_OPEN);

endmodule

// File: rtl/smm_srst_replay.sv
module smm_srst_replay (
  input  logic clk,
  input  logic rst_n,
  input  logic hold_off,
  input  logic req,
  output logic pulse
);

  logic pend_q;
  logic pend_d;
  logic pend_en;
  logic pulse_q;
  logic pulse_d;
  logic fire;

  assign fire = !hold_off && (pend_q || req);

  // Next state of the pending flag and of the outgoing pulse.
  always_comb begin
    pulse_d = fire;
    pend_d  = pend_q;
    pend_en = 1'b0;
    if (fire) begin
      pend_d  = 1'b0;
      pend_en = pend_q;
    end else if (hold_off && req) begin
      pend_d  = 1'b1;
      pend_en = !pend_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       pend_q <= 1'b0;
    else if (pend_en) pend_q <= pend_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pulse_q <= 1'b0;
    else        pulse_q <= pulse_d;
  end

  assign pulse = pulse_q;

endmodule

// File: rtl/smm_srst_gate.sv
module smm_srst_gate
  import smm_srst_pkg::*;
#(
  parameter int unsigned GUARD_CYCLES = GUARD_DEFAULT,
  parameter int unsigned SYNC_STAGES  = SYNC_DEFAULT
) (
  input  logic clk,
  input  logic glb_rst_n,
  input  logic smm_act_n,
  input  logic srst_req,
  output logic srst_pulse,
  output logic cpu_hard_rst_n
);

  logic        rst_n_int;
  logic        hold_off;
  gate_state_e gate_state;

  // The hard reset is never gated.
  assign cpu_hard_rst_n = glb_rst_n;

  smm_srst_rst_sync #(.STAGES(SYNC_STAGES)) u_rst_sync (
    .clk        (clk),
    .arst_n     (glb_rst_n),
    .rst_n_sync (rst_n_int)
  );

  smm_srst_exit_guard #(.GUARD_CYCLES(GUARD_CYCLES)) u_guard (
    .clk        (clk),
    .rst_n      (rst_n_int),
    .smm_act_n  (smm_act_n),
    .hold_off   (hold_off),
    .gate_state (gate_state)
  );

  smm_srst_replay u_replay (
    .clk      (clk),
    .rst_n    (rst_n_int),
    .hold_off (hold_off),
    .req      (srst_req),
    .pulse    (srst_pulse)
  );

endmodule

// File: rtl/smm_srst_gate_chk.sv
module smm_srst_gate_chk #(
  parameter int unsigned GUARD_CYCLES = 20
) (
  input logic clk,
  input logic rst_n,
  input logic smm_act_n,
  input logic srst_req,
  input logic srst_pulse
);

  localparam int unsigned CW = (GUARD_CYCLES < 2) ? 1 : $clog2(GUARD_CYCLES + 1);

  logic          smm_seen_n;
  logic [CW-1:0] win_cnt;
  logic          exit_now;
  logic          blk_model;

  assign exit_now  = smm_act_n && !smm_seen_n;
  assign blk_model = !smm_act_n || exit_now || (win_cnt != '0);

  // Independent window counter, measured from the exit edge.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      smm_seen_n <= 1'b1;
      win_cnt    <= '0;
    end else begin
      smm_seen_n <= smm_act_n;
      if (!smm_act_n)          win_cnt <= '0;
      else if (exit_now)       win_cnt <= CW'(GUARD_CYCLES);
      else if (win_cnt != '0)  win_cnt <= win_cnt - 1'b1;
    end
  end

  // R2: no pulse after a cycle spent in management mode
  a_r2_smm_holds_off: assert property (@(posedge clk) disable iff (!rst_n)
    !smm_act_n |=> !srst_pulse);

  // R3: no pulse after the exit cycle or any cycle of the guard window
  a_r3_exit_edge_holds_off: assert property (@(posedge clk) disable iff (!rst_n)
    exit_now |=> !srst_pulse);

  a_r3_window_holds_off: assert property (@(posedge clk) disable iff (!rst_n)
    (win_cnt != '0) |=> !srst_pulse);

  // R4: a replayed pulse lasts a single cycle
  a_r4_single_replay: assert property (@(posedge clk) disable iff (!rst_n)
    (srst_pulse && !srst_req) |=> !srst_pulse);

  // R7: an open gate passes a request through in one cycle
  a_r7_open_passes: assert property (@(posedge clk) disable iff (!rst_n)
    (!blk_model && srst_req) |=> srst_pulse);

endmodule

bind smm_srst_gate smm_srst_gate_chk #(.GUARD_CYCLES(GUARD_CYCLES)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n_int),
  .smm_act_n  (smm_act_n),
  .srst_req   (srst_req),
  .srst_pulse (srst_pulse)
);

// File: tb/tb_smm_srst_gate.sv
module tb_smm_srst_gate;

  localparam int CLK_PERIOD = 10;
  localparam int GUARD      = 20;
  localparam int WATCHDOG   = 20000;

  // Each entry: {smm_act_n, srst_req, expected srst_pulse after the edge}
  localparam logic [2:0] VEC [0:8] = '{
    3'b100,  // idle
    3'b111,  // R7 open request passes
    3'b100,
    3'b111,  // R7
    3'b111,  // R7 held request pulses again
    3'b100,
    3'b010,  // R2 request inside mode, held
    3'b000,  // R2
    3'b010   // R5 second request merges
  };

  logic clk;
  logic glb_rst_n;
  logic smm_act_n;
  logic srst_req;
  logic srst_pulse;
  logic cpu_hard_rst_n;

  int n_chk;
  int n_bad;
  int cyc_cnt;
  bit done;

  smm_srst_gate #(.GUARD_CYCLES(GUARD)) dut (
    .clk            (clk),
    .glb_rst_n      (glb_rst_n),
    .smm_act_n      (smm_act_n),
    .srst_req       (srst_req),
    .srst_pulse     (srst_pulse),
    .cpu_hard_rst_n (cpu_hard_rst_n)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input logic act, input logic exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %b expected %b (t=%0t)", tag, act, exp, $time);
    end
  endtask

  // Called at a falling edge: drive, take one rising edge, sample at next falling edge.
  task automatic cyc(input logic smm_n, input logic rq, input logic exp, input string tag);
    smm_act_n = smm_n;
    srst_req  = rq;
    @(posedge clk);
    @(negedge clk);
    check(srst_pulse, exp, tag);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc_cnt++;
    if (cyc_cnt > WATCHDOG && !done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: got hung expected finish");
      finish_run();
    end
  end

  initial begin
    n_chk = 0; n_bad = 0; cyc_cnt = 0; done = 1'b0;
    glb_rst_n = 1'b0;
    smm_act_n = 1'b1;
    srst_req  = 1'b0;
    repeat (3) @(negedge clk);
    check(srst_pulse, 1'b0, "R1 pulse low in reset");
    check(cpu_hard_rst_n, 1'b0, "R8 hard reset follows low");
    glb_rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check(cpu_hard_rst_n, 1'b1, "R8 hard reset follows high");
    cyc(1'b1, 1'b0, 1'b0, "R1 idle after release");

    // Table walk
    for (int i = 0; i < 9; i++) begin
      cyc(VEC[i][2], VEC[i][1], VEC[i][0], $sformatf("R2/R5/R7 vector %0d", i));
    end

    // Exit: hold-off through exit cycle GUARD+1, then one merged replay
    for (int k = 1; k <= GUARD + 1; k++) cyc(1'b1, 1'b0, 1'b0, "R3 guard window");
    cyc(1'b1, 1'b0, 1'b1, "R4 R5 replay after guard");
    cyc(1'b1, 1'b0, 1'b0, "R4 replay is one cycle");
    cyc(1'b1, 1'b0, 1'b0, "R5 no second replay");

    // Re-entry during the guard window restarts the hold-off
    cyc(1'b0, 1'b1, 1'b0, "R2 request in mode");
    for (int k = 1; k <= 11; k++) cyc(1'b1, 1'b0, 1'b0, "R6 first window");
    for (int k = 0; k < 3; k++)   cyc(1'b0, 1'b0, 1'b0, "R6 re-entry");
    for (int k = 1; k <= GUARD + 1; k++) cyc(1'b1, 1'b0, 1'b0, "R6 full window again");
    cyc(1'b1, 1'b0, 1'b1, "R6 replay after second exit");
    cyc(1'b1, 1'b0, 1'b0, "R4 single replay");

    // Request on the last held-off cycle is still replayed
    cyc(1'b0, 1'b0, 1'b0, "R2 mode entry");
    for (int k = 1; k <= GUARD; k++) cyc(1'b1, 1'b0, 1'b0, "R3 window");
    cyc(1'b1, 1'b1, 1'b0, "R3 last held-off cycle");
    cyc(1'b1, 1'b0, 1'b1, "R4 boundary replay");
    cyc(1'b1, 1'b0, 1'b0, "R4 boundary single");
    cyc(1'b1, 1'b1, 1'b1, "R7 open again");
    cyc(1'b1, 1'b0, 1'b0, "R7 open again ends");

    // Global reset discards a pending replay
    cyc(1'b0, 1'b1, 1'b0, "R2 request before reset");
    glb_rst_n = 1'b0;
    smm_act_n = 1'b1;
    srst_req  = 1'b0;
    #1;
    check(cpu_hard_rst_n, 1'b0, "R8 hard reset passes immediately");
    repeat (2) @(negedge clk);
    check(srst_pulse, 1'b0, "R8 pulse low during reset");
    glb_rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check(cpu_hard_rst_n, 1'b1, "R8 hard reset released");
    for (int k = 0; k < 30; k++) cyc(1'b1, 1'b0, 1'b0, "R8 pending discarded");
    cyc(1'b1, 1'b1, 1'b1, "R1 gate idle after reset");
    cyc(1'b1, 1'b0, 1'b0, "R1 gate idle after reset end");

    finish_run();
  end

endmodule